// File: doc/BRIEF.md
# Fixed-Block Serial Exchange DMA

This engine moves one fixed block of sixteen 32-bit words (64 bytes) between main DRAM and a small 16-word peripheral RAM. Software loads a DRAM byte address into a base register and then writes one of two trigger registers. The trigger register picks the direction. The value written to the trigger must be the fixed peripheral key address 0x1FC007C0. Any other value is treated as a fault: the engine sets a sticky error flag and halts until reset.

In the DRAM-to-peripheral direction, the words are copied first, one per clock. A one-cycle "process" strobe then tells the logic behind the peripheral RAM to act on the new contents. In the peripheral-to-DRAM direction the order is reversed. A one-cycle "refresh" strobe comes first, so that logic can update the RAM, and only then are the sixteen words copied out to DRAM. Each accepted trigger produces a one-cycle completion interrupt a fixed number of cycles later. The engine stays busy until then and ignores register writes during that time.

Both memories are read combinationally through their index ports and written on the clock edge.

Top module: `fixblk_dma`

## Requirements
- R1: A write to the to-peripheral trigger (cfg_sel = 2'b01) with the key value copies DRAM word base+i into peripheral word i for i = 0..15, one word per cycle. The copy runs in the 16 cycles that start right after the trigger edge. DRAM is left unchanged.
- R2: A write to the from-peripheral trigger (cfg_sel = 2'b10) with the key value copies peripheral word i into DRAM word base+i for i = 0..15. The peripheral RAM is left unchanged apart from what the refresh step does.
- R3: In a to-peripheral transfer, proc_pulse is high for exactly one cycle. That cycle comes right after the last of the 16 peripheral writes, which is the 17th cycle after the trigger edge.
- R4: In a from-peripheral transfer, refr_pulse is high for exactly one cycle, the first cycle after the trigger edge. The 16 DRAM writes follow in the next 16 cycles.
- R5: The DRAM word index is the byte address written to the base register (cfg_sel = 2'b00) divided by 4. The two low bits are dropped. The index for word i is base+i modulo 2^DRAM_AW.
- R6: irq is high for one cycle, exactly IRQ_DELAY cycles after the edge that accepts a trigger. busy is high from that edge until irq is raised.
- R7: While busy is high, trigger writes and base-register writes have no effect.
- R8: A trigger write whose value is not 0x1FC007C0 sets err. It performs no copy, raises no irq and leaves busy low.
- R9: err stays set until reset. While it is set, every trigger write is ignored.
- R10: After reset, busy, irq, err and both strobes are low, and neither memory write enable is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register select: 00 base, 01 to-peripheral trigger, 10 from-peripheral trigger |
| cfg_wdata | input | 32 | Register write data |
| dram_idx | output | DRAM_AW | DRAM word index for read or write |
| dram_rdata | input | 32 | DRAM read data at dram_idx |
| dram_we | output | 1 | DRAM write enable |
| dram_wdata | output | 32 | DRAM write data |
| pram_idx | output | 4 | Peripheral RAM word index |
| pram_rdata | input | 32 | Peripheral RAM read data at pram_idx |
| pram_we | output | 1 | Peripheral RAM write enable |
| pram_wdata | output | 32 | Peripheral RAM write data |
| proc_pulse | output | 1 | One-cycle process strobe after an inbound copy |
| refr_pulse | output | 1 | One-cycle refresh strobe before an outbound copy |
| irq | output | 1 | One-cycle completion interrupt |
| busy | output | 1 | Transfer in progress |
| err | output | 1 | Sticky bad-key fault |

## Verification
The bench builds the engine with DRAM_AW = 8 and IRQ_DELAY = 40. The 8-bit word index makes a 256-word DRAM model practical, and it lets base addresses near index 255 exercise the wraparound of R5. The short delay is still longer than the 17-cycle copy plus strobe, so each transfer's full window fits in a few dozen cycles. That keeps the triggers issued mid-transfer, the halt after a bad key and the recovery through reset all within a short run.

// File: rtl/fixblk_pkg.sv
package fixblk_pkg;
  typedef enum logic [2:0] {
    S_IDLE,
    S_FILL,
    S_PROC,
    S_REFR,
    S_DRAIN
  } seq_e;

  localparam logic [1:0] SEL_BASE   = 2'b00;
  localparam logic [1:0] SEL_TOPR   = 2'b01;
  localparam logic [1:0] SEL_FROMPR = 2'b10;
endpackage

// File: rtl/fixblk_regs.sv
module fixblk_regs
  import fixblk_pkg::*;
#(
  parameter int          AW  = 21,
  parameter logic [31:0] KEY = 32'h1FC0_07C0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [1:0]    cfg_sel,
  input  logic [31:0]   cfg_wdata,
  input  logic          busy,
  output logic [AW-1:0] base,
  output logic          start,
  output logic          start_dir,
  output logic          err
);
  logic [AW-1:0] base_q, base_d;
  logic          err_q, err_d;
  logic          trig, accept, key_ok, base_en;

  always_comb begin
    trig      = cfg_we && (cfg_sel == SEL_TOPR || cfg_sel == SEL_FROMPR);
    accept    = trig && !busy && !err_q;
    key_ok    = (cfg_wdata == KEY);
    start     = accept && key_ok;
    start_dir = (cfg_sel == SEL_TOPR);
    base_en   = cfg_we && (cfg_sel == SEL_BASE) && !busy;
    base_d    = cfg_wdata[AW+1:2];
    err_d     = err_q || (accept && !key_ok);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      err_q  <= 1'b0;
    end else begin
      if (base_en) base_q <= base_d;
      err_q <= err_d;
    end
  end

  assign base = base_q;
  assign err  = err_q;
endmodule

// File: rtl/fixblk_seq.sv
module fixblk_seq
  import fixblk_pkg::*;
#(
  parameter int AW    = 21,
  parameter int WORDS = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     start,
  input  logic                     start_dir,
  input  logic [AW-1:0]            base,
  output logic [AW-1:0]            dram_idx,
  output logic                     dram_we,
  output logic [$clog2(WORDS)-1:0] pram_idx,
  output logic                     pram_we,
  output logic                     proc_pulse,
  output logic                     refr_pulse
);
  localparam int CW = $clog2(WORDS);
  localparam logic [CW-1:0] LAST = CW'(WORDS - 1);

  seq_e          st_q, st_d;
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    unique case (st_q)
      S_IDLE: if (start) begin
        st_d  = start_dir ? S_FILL : S_REFR;
        cnt_d = '0;
      end
      S_FILL: if (cnt_q == LAST) st_d = S_PROC;
              else cnt_d = cnt_q + 1'b1;
      S_PROC: st_d = S_IDLE;
      S_REFR: begin
        st_d  = S_DRAIN;
        cnt_d = '0;
      end
      S_DRAIN: if (cnt_q == LAST) st_d = S_IDLE;
               else cnt_d = cnt_q + 1'b1;
      default: st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= S_IDLE;
      cnt_q <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
    end
  end

  assign dram_idx   = base + AW'(cnt_q);
  assign pram_idx   = cnt_q;
  assign pram_we    = (st_q == S_FILL);
  assign dram_we    = (st_q == S_DRAIN);
  assign proc_pulse = (st_q == S_PROC);
  assign refr_pulse = (st_q == S_REFR);

  // R3
  fill_then_proc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    proc_pulse |-> $past(pram_we));
  // R4
  refr_then_drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    refr_pulse |=> dram_we);
  // R7
  start_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> (st_q == S_IDLE));
endmodule

// File: rtl/fixblk_timer.sv
module fixblk_timer #(
  parameter int DELAY = 2304
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy,
  output logic irq
);
  localparam int TW = $clog2(DELAY + 1);
  localparam logic [TW-1:0] FIRE = TW'(DELAY - 1);

  logic [TW-1:0] cnt_q, cnt_d;
  logic          busy_q, busy_d, irq_q, irq_d;

  always_comb begin
    irq_d  = busy_q && (cnt_q == FIRE);
    cnt_d  = cnt_q;
    busy_d = busy_q;
    if (start) begin
      cnt_d  = '0;
      busy_d = 1'b1;
    end else if (irq_d) begin
      busy_d = 1'b0;
    end else if (busy_q) begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      busy_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      busy_q <= busy_d;
      irq_q  <= irq_d;
    end
  end

  assign busy = busy_q;
  assign irq  = irq_q;

  // R6
  irq_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);
  // R6
  irq_ends_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> $past(busy));
endmodule

// File: rtl/fixblk_dma.sv
module fixblk_dma #(
  parameter int          DRAM_AW   = 21,
  parameter int          IRQ_DELAY = 2304,
  parameter logic [31:0] KEY_ADDR  = 32'h1FC0_07C0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_we,
  input  logic [1:0]         cfg_sel,
  input  logic [31:0]        cfg_wdata,
  output logic [DRAM_AW-1:0] dram_idx,
  input  logic [31:0]        dram_rdata,
  output logic               dram_we,
  output logic [31:0]        dram_wdata,
  output logic [3:0]         pram_idx,
  input  logic [31:0]        pram_rdata,
  output logic               pram_we,
  output logic [31:0]        pram_wdata,
  output logic               proc_pulse,
  output logic               refr_pulse,
  output logic               irq,
  output logic               busy,
  output logic               err
);
  localparam int WORDS = 16;

  logic [DRAM_AW-1:0] base;
  logic               start, start_dir;

  fixblk_regs #(.AW(DRAM_AW), .KEY(KEY_ADDR)) regs_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .busy(busy), .base(base), .start(start),
    .start_dir(start_dir), .err(err)
  );

  fixblk_seq #(.AW(DRAM_AW), .WORDS(WORDS)) seq_i (
    .clk(clk), .rst_n(rst_n), .start(start), .start_dir(start_dir),
    .base(base), .dram_idx(dram_idx), .dram_we(dram_we),
    .pram_idx(pram_idx), .pram_we(pram_we), .proc_pulse(proc_pulse),
    .refr_pulse(refr_pulse)
  );

  fixblk_timer #(.DELAY(IRQ_DELAY)) timer_i (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .irq(irq)
  );

  assign pram_wdata = dram_rdata;
  assign dram_wdata = pram_rdata;

  // R9
  err_halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> !busy);
  // R9
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> err);
  // R1
  one_direction_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pram_we |-> (!dram_we && busy));
endmodule

// File: tb/fixblk_dma_tb_top.sv
module fixblk_dma_tb_top;
  localparam int AW = 8;
  localparam int ND = 1 << AW;
  localparam int DLY = 40;
  localparam logic [31:0] KEY = 32'h1FC0_07C0;
  localparam logic [32:0] VEC [4] = '{
    {1'b1, 32'h0000_0040}, {1'b0, 32'h0000_0083},
    {1'b1, 32'h0000_03E8}, {1'b0, 32'h0000_03F0}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [1:0] cfg_sel = 2'b11;
  logic [31:0] cfg_wdata = '0;
  logic [AW-1:0] dram_idx;
  logic [31:0] dram_rdata, dram_wdata, pram_rdata, pram_wdata;
  logic [3:0] pram_idx;
  logic dram_we, pram_we, proc_pulse, refr_pulse, irq, busy, err;

  logic [31:0] mem_d [ND];
  logic [31:0] mem_p [16];
  logic [31:0] exp_d [ND];
  logic [31:0] exp_p [16];

  int n_chk = 0, n_fail = 0, cyc = 0, t_trig = 0;
  int n_irq, n_proc, n_refr, n_pw, n_dw, irq_at, proc_at, refr_at, last_pw, first_dw;

  always #5 clk = ~clk;

  fixblk_dma #(.DRAM_AW(AW), .IRQ_DELAY(DLY)) dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .dram_idx(dram_idx), .dram_rdata(dram_rdata),
    .dram_we(dram_we), .dram_wdata(dram_wdata), .pram_idx(pram_idx),
    .pram_rdata(pram_rdata), .pram_we(pram_we), .pram_wdata(pram_wdata),
    .proc_pulse(proc_pulse), .refr_pulse(refr_pulse), .irq(irq),
    .busy(busy), .err(err)
  );

  function automatic logic [31:0] scr(int i);
    return 32'h5A00_0000 | (i * 32'h0101);
  endfunction

  assign dram_rdata = mem_d[dram_idx];
  assign pram_rdata = mem_p[pram_idx];

  always @(posedge clk) begin
    if (dram_we) mem_d[dram_idx] <= dram_wdata;
    if (pram_we) mem_p[pram_idx] <= pram_wdata;
    if (refr_pulse) for (int i = 0; i < 16; i++) mem_p[i] <= mem_p[i] ^ scr(i);
  end

  always @(negedge clk) begin
    if (irq) begin n_irq++; irq_at = cyc; end
    if (proc_pulse) begin n_proc++; proc_at = cyc; end
    if (refr_pulse) begin n_refr++; refr_at = cyc; end
    if (pram_we) begin n_pw++; last_pw = cyc; end
    if (dram_we) begin if (n_dw == 0) first_dw = cyc; n_dw++; end
    cyc++;
  end

  task automatic clear_obs();
    n_irq = 0; n_proc = 0; n_refr = 0; n_pw = 0; n_dw = 0;
    irq_at = -1; proc_at = -1; refr_at = -1; last_pw = -1; first_dw = -1;
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic reg_wr(input logic [1:0] sel, input logic [31:0] val);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = val;
    @(posedge clk);
    t_trig = cyc;
    @(negedge clk);
    cfg_we = 1'b0; cfg_sel = 2'b11;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  function automatic int mism();
    int m = 0;
    for (int i = 0; i < ND; i++) if (mem_d[i] !== exp_d[i]) m++;
    for (int i = 0; i < 16; i++) if (mem_p[i] !== exp_p[i]) m++;
    return m;
  endfunction

  task automatic model(input bit to_p, input logic [31:0] addr);
    logic [AW-1:0] b = addr[AW+1:2];
    for (int i = 0; i < 16; i++) begin
      if (to_p) exp_p[i] = exp_d[AW'(b + AW'(i))];
      else begin
        exp_p[i] = exp_p[i] ^ scr(i);
        exp_d[AW'(b + AW'(i))] = exp_p[i];
      end
    end
  endtask

  task automatic xfer(input bit to_p, input logic [31:0] addr);
    model(to_p, addr);
    clear_obs();
    reg_wr(2'b00, addr);
    reg_wr(to_p ? 2'b01 : 2'b10, KEY);
    idle(DLY + 3);
    chk(n_irq == 1 && irq_at - t_trig == DLY, "R6 irq delay", irq_at - t_trig, DLY);
    chk(mism() == 0, to_p ? "R1 R5 contents" : "R2 R5 contents", mism(), 0);
    if (to_p) begin
      chk(n_pw == 16 && last_pw - t_trig == 15, "R1 beats", n_pw, 16);
      chk(n_proc == 1 && proc_at - t_trig == 16, "R3 proc after copy", proc_at - t_trig, 16);
    end else begin
      chk(n_refr == 1 && refr_at == t_trig, "R4 refresh first", refr_at - t_trig, 0);
      chk(n_dw == 16 && first_dw - t_trig == 1, "R4 copy after refresh", first_dw - t_trig, 1);
    end
  endtask

  initial begin
    #(200000 * 10);
    chk(1'b0, "watchdog", 0, 1);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    for (int i = 0; i < ND; i++) begin mem_d[i] = 32'hD000_0000 + i * 7; exp_d[i] = mem_d[i]; end
    for (int i = 0; i < 16; i++) begin mem_p[i] = 32'hC0DE_0000 + i; exp_p[i] = mem_p[i]; end
    clear_obs();
    idle(3);
    rst_n = 1'b1;
    idle(2);
    // R10 reset state
    chk({busy, irq, err, proc_pulse, refr_pulse, dram_we, pram_we} == 7'b0, "R10 reset",
        {busy, irq, err, proc_pulse, refr_pulse, dram_we, pram_we}, 0);

    for (int v = 0; v < 4; v++) xfer(VEC[v][32], VEC[v][31:0]);

    // R7 triggers and base writes ignored while busy
    model(1'b1, 32'h100);
    clear_obs();
    reg_wr(2'b00, 32'h100);
    reg_wr(2'b01, KEY);
    idle(4);
    reg_wr(2'b00, 32'h200);
    reg_wr(2'b10, KEY);
    idle(DLY + 5);
    chk(n_irq == 1 && n_dw == 0, "R7 trigger ignored", n_irq, 1);
    chk(mism() == 0, "R7 contents", mism(), 0);
    model(1'b0, 32'h100);
    clear_obs();
    reg_wr(2'b10, KEY);
    idle(DLY + 3);
    chk(mism() == 0 && n_irq == 1, "R7 base kept", mism(), 0);

    // R8 bad key
    clear_obs();
    reg_wr(2'b01, KEY + 32'h4);
    idle(DLY + 5);
    chk(err == 1'b1, "R8 err set", err, 1);
    chk(n_irq == 0 && n_pw == 0 && busy == 1'b0, "R8 no transfer", n_irq + n_pw, 0);

    // R9 halted
    clear_obs();
    reg_wr(2'b10, KEY);
    idle(DLY + 5);
    chk(n_irq == 0 && n_dw == 0 && n_refr == 0, "R9 halted", n_irq + n_dw, 0);
    chk(err == 1'b1 && mism() == 0, "R9 sticky", err, 1);

    @(negedge clk); rst_n = 1'b0;
    idle(2);
    rst_n = 1'b1;
    idle(1);
    chk(err == 1'b0 && busy == 1'b0, "R10 R9 reset clears err", err, 0);
    xfer(1'b1, 32'h10);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule